// File: doc/BRIEF.md
# Two-Lane Error-Feedback Delta-Sigma Requantizer

This block shortens a signed 13-bit sample stream to signed 4-bit codes for a multi-bit DAC. Its quantization error is pushed towards high frequencies with a noise transfer function (1 − z⁻¹)ⁿ. The order n is a parameter, and orders 2 and 3 are supported. The block accepts two consecutive samples on each edge of a half-rate clock. Lane 0 carries the earlier (even) sample and lane 1 the later (odd) one. Downstream, the DAC is meant to see lane 0 first and lane 1 second.

The loop uses an error-feedback form. A correction term, built from past quantization errors, is added to each input word. The four most significant bits of the sum, saturated, become the output. The difference between the output and the sum is stored as the new error. Two full-rate steps are unrolled into one clock cycle. The odd lane therefore takes the even lane's fresh error combinationally, and the older errors come from a small register history. Each stored error is limited in magnitude, so that a saturated quantizer cannot drive the loop into runaway growth.

Top module: `ds2_shaper`

## Requirements
- R1: A synchronous reset, active high, clears both output registers and every stored error term to zero. After reset the loop behaves as if no sample had ever been processed.
- R2: Inputs are two's complement and 13 bits wide. Each output code is two's complement and 4 bits wide. The code equals floor(v / 512), saturated to the range −8 to +7, where v is the lane's corrected sum.
- R3: With ORDER=2, the corrected sum is v[k] = x[k] − 2·e[k−1] + e[k−2]. The error is e[k] = y[k]·512 − v[k].
- R4: With ORDER=3, the corrected sum is v[k] = x[k] − 3·e[k−1] + 3·e[k−2] − e[k−3], with the same error definition.
- R5: Within one cycle, lane 1 is the sample that follows lane 0. Lane 1's term e[k−1] is the error just produced by lane 0 in the same cycle. From a cleared state, the pair (300, 0) therefore yields 0 on lane 0 and 1 on lane 1.
- R6: Outputs are registered. A pair presented with the valid strobe high appears on y0/y1 after the next rising clock edge, and not before it.
- R7: While the valid strobe is low, the outputs and the error history do not change, whatever the input words carry.
- R8: Each stored error is clamped to the range −2048 to +2048 before it is used again. This holds the loop bounded when the input sits at full scale.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Half-rate clock |
| rst | input | 1 | Synchronous reset, active high |
| vld | input | 1 | Input pair valid strobe |
| x0 | input | 13 | Even (earlier) input sample, signed |
| x1 | input | 13 | Odd (later) input sample, signed |
| y0 | output | 4 | Even output code, signed |
| y1 | output | 4 | Odd output code, signed |

## Verification
The assertions check three things on every cycle:
- Outputs are cleared after reset.
- Outputs hold while the strobe is low.
- In each lane, an unsaturated code leaves an error in the interval (−512, 0].

The bench's scenarios show the rest:
- The exact noise-shaped sequence, compared against a serial full-rate loop that is run at both orders.
- The lane hand-off of the even error to the odd lane.
- Behaviour at full-scale inputs, where the error clamp matters.
- The one-cycle output latency.

// File: rtl/ds2_shaper.sv
module ds2_shaper #(
  parameter int IN_W  = 13,
  parameter int OUT_W = 4,
  parameter int ORDER = 2
) (
  input  logic                    clk,
  input  logic                    rst,
  input  logic                    vld,
  input  logic signed [IN_W-1:0]  x0,
  input  logic signed [IN_W-1:0]  x1,
  output logic signed [OUT_W-1:0] y0,
  output logic signed [OUT_W-1:0] y1
);
  localparam int SH    = IN_W - OUT_W;
  localparam int ACC_W = IN_W + 6;
  localparam int EMAX  = 2 ** (SH + 2);
  localparam int YMAX  = 2 ** (OUT_W - 1) - 1;
  localparam int YMIN  = -(2 ** (OUT_W - 1));

  typedef logic signed [ACC_W-1:0] acc_t;

  function automatic int coef(int i);
    int c;
    c = 1;
    for (int j = 0; j < i; j++) c = c * (ORDER - j) / (j + 1);
    return (i % 2 == 1) ? -c : c;
  endfunction

  function automatic logic signed [OUT_W-1:0] quant(acc_t v);
    acc_t t;
    t = v >>> SH;
    if (t > acc_t'(YMAX)) return OUT_W'(YMAX);
    if (t < acc_t'(YMIN)) return OUT_W'(YMIN);
    return t[OUT_W-1:0];
  endfunction

  function automatic acc_t ferr(acc_t v, logic signed [OUT_W-1:0] y);
    acc_t e;
    e = (acc_t'(y) <<< SH) - v;
    if (e > acc_t'(EMAX)) e = acc_t'(EMAX);
    else if (e < acc_t'(-EMAX)) e = acc_t'(-EMAX);
    return e;
  endfunction

  acc_t eh [ORDER];
  acc_t v0, v1, e0, e1;
  logic signed [OUT_W-1:0] q0, q1;

  always_comb begin
    v0 = acc_t'(x0);
    for (int i = 1; i <= ORDER; i++) v0 = v0 + acc_t'(coef(i)) * eh[i-1];
    q0 = quant(v0);
    e0 = ferr(v0, q0);
    v1 = acc_t'(x1) + acc_t'(coef(1)) * e0;
    for (int i = 2; i <= ORDER; i++) v1 = v1 + acc_t'(coef(i)) * eh[i-2];
    q1 = quant(v1);
    e1 = ferr(v1, q1);
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      y0 <= '0;
      y1 <= '0;
      for (int i = 0; i < ORDER; i++) eh[i] <= '0;
    end else if (vld) begin
      y0 <= q0;
      y1 <= q1;
      for (int i = 0; i < ORDER; i++)
        eh[i] <= (i == 0) ? e1 : (i == 1) ? e0 : eh[(i >= 2) ? i - 2 : 0];
    end
  end

  logic rst_d;
  always_ff @(posedge clk) rst_d <= rst;

  always @(posedge clk)
    if (rst_d) assert_reset_clear_R1: assert (y0 == '0 && y1 == '0);

  assert_hold_idle_R7: assert property (@(posedge clk) disable iff (rst)
    !vld |=> ($stable(y0) && $stable(y1)));

  assert_err_even_R2: assert property (@(posedge clk) disable iff (rst)
    (q0 > YMIN && q0 < YMAX) |-> (e0 <= 0 && e0 > -(2 ** SH)));

  assert_err_odd_R2: assert property (@(posedge clk) disable iff (rst)
    (q1 > YMIN && q1 < YMAX) |-> (e1 <= 0 && e1 > -(2 ** SH)));
endmodule

// File: tb/sim_ds2_shaper.sv
module sim_ds2_shaper;
  logic clk = 1'b0;
  logic rst = 1'b1;
  logic vld = 1'b0;
  logic signed [12:0] x0 = '0, x1 = '0;
  logic signed [3:0] ya0, ya1, yb0, yb1;
  int errors = 0, checks = 0;
  int hist [2][3];

  always #5 clk = ~clk;

  ds2_shaper #(.IN_W(13), .OUT_W(4), .ORDER(2)) u0 (
    .clk(clk), .rst(rst), .vld(vld), .x0(x0), .x1(x1), .y0(ya0), .y1(ya1));
  ds2_shaper #(.IN_W(13), .OUT_W(4), .ORDER(3)) u1 (
    .clk(clk), .rst(rst), .vld(vld), .x0(x0), .x1(x1), .y0(yb0), .y1(yb1));

  task automatic chk(string req, int act, int exp);
    checks++;
    if (act != exp) begin
      errors++;
      $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  function automatic int rcoef(int o, int i);
    if (o == 0) return (i == 1) ? -2 : (i == 2) ? 1 : 0;
    return (i == 1) ? -3 : (i == 2) ? 3 : -1;
  endfunction

  function automatic int ref_one(int o, int x);
    int v, y, e;
    v = x;
    for (int i = 0; i < 3; i++) v += rcoef(o, i + 1) * hist[o][i];
    y = v >>> 9;
    if (y > 7) y = 7;
    if (y < -8) y = -8;
    e = y * 512 - v;
    if (e > 2048) e = 2048;
    if (e < -2048) e = -2048;
    hist[o][2] = hist[o][1];
    hist[o][1] = hist[o][0];
    hist[o][0] = e;
    return y;
  endfunction

  task automatic pair(int a, int b, string ta, string tb);
    int ea0, ea1, eb0, eb1;
    ea0 = ref_one(0, a); ea1 = ref_one(0, b);
    eb0 = ref_one(1, a); eb1 = ref_one(1, b);
    x0 = 13'(a); x1 = 13'(b); vld = 1'b1;
    @(posedge clk); @(negedge clk);
    vld = 1'b0;
    chk(ta, int'(ya0), ea0); chk(ta, int'(ya1), ea1);
    chk(tb, int'(yb0), eb0); chk(tb, int'(yb1), eb1);
  endtask

  task automatic t_reset();
    rst = 1'b1; vld = 1'b0;
    repeat (2) @(negedge clk);
    for (int o = 0; o < 2; o++) for (int i = 0; i < 3; i++) hist[o][i] = 0;
    chk("R1", int'(ya0), 0); chk("R1", int'(ya1), 0);
    chk("R1", int'(yb0), 0); chk("R1", int'(yb1), 0);
    rst = 1'b0;
  endtask

  task automatic t_lane_order();
    pair(300, 0, "R5", "R5");
    chk("R5", int'(ya0), 0); chk("R5", int'(ya1), 1); chk("R5", int'(yb1), 1);
  endtask

  task automatic t_dc();
    for (int k = 0; k < 40; k++) pair(700, 700, "R3", "R4");
    for (int k = 0; k < 20; k++) pair(-1234, -1234, "R3", "R4");
  endtask

  task automatic t_tri();
    int s, d;
    s = 0; d = 150;
    for (int k = 0; k < 80; k++) begin
      pair(s, s + d / 2, "R3", "R4");
      s += d;
      if (s > 2000 || s < -2000) d = -d;
    end
  endtask

  task automatic t_sat();
    for (int k = 0; k < 30; k++) pair(4095, 4095, "R8", "R8");
    chk("R2", int'(ya0), 7);
    for (int k = 0; k < 30; k++) pair(-4096, -4096, "R8", "R8");
    for (int k = 0; k < 10; k++) pair(0, 0, "R2", "R2");
  endtask

  task automatic t_hold();
    int p0, p1, p2, p3;
    pair(900, -300, "R3", "R4");
    p0 = int'(ya0); p1 = int'(ya1); p2 = int'(yb0); p3 = int'(yb1);
    x0 = 13'(4000); x1 = 13'(-4000); vld = 1'b0;
    repeat (3) @(negedge clk);
    chk("R7", int'(ya0), p0); chk("R7", int'(ya1), p1);
    chk("R7", int'(yb0), p2); chk("R7", int'(yb1), p3);
    for (int k = 0; k < 5; k++) pair(900, -300, "R7", "R7");
  endtask

  task automatic t_latency();
    int p0, ea0, ea1, eb0, eb1;
    p0 = int'(ya0);
    ea0 = ref_one(0, 3000); ea1 = ref_one(0, 3000);
    eb0 = ref_one(1, 3000); eb1 = ref_one(1, 3000);
    x0 = 13'(3000); x1 = 13'(3000); vld = 1'b1;
    #2;
    chk("R6", int'(ya0), p0);
    @(posedge clk); @(negedge clk);
    vld = 1'b0;
    chk("R6", int'(ya0), ea0); chk("R6", int'(ya1), ea1);
    chk("R6", int'(yb0), eb0); chk("R6", int'(yb1), eb1);
  endtask

  initial begin
    #(1_000_000);
    errors++; checks++;
    $display("FAIL watchdog expired actual=running expected=done");
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end

  initial begin
    @(negedge clk);
    t_reset();
    t_lane_order();
    t_dc();
    t_tri();
    t_hold();
    t_latency();
    t_sat();
    t_reset();
    t_lane_order();
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end
endmodule